// File: doc/BRIEF.md
# Voice register indirect access port

This block lets a host reach a large bank of per-voice synthesizer registers through four narrow bus locations. The host first writes a voice number and a function code into two select registers, then reads or writes a 16-bit data window. Voice and function together address one word in a store of 32 voices with 16 word registers each. The data window can be used as a whole word, or as two byte lanes that merge into the stored word or are taken out of it.

Function codes select the operation. Writes to a voice register use one range of codes, and reads of the same register use that range moved up by 0x80. A voice-count register and a global control register share the same data window. Bit 0 of the control register is a run flag. Per-voice writes only take effect while it is set. Clearing it also loads the voice count with a fixed value and drops two enable bits. The two enable bits and the run flag leave the block as outputs for the synthesis logic.

Bus locations are numbered by `bus_addr`: 0 is voice select, 1 is function select, 2 is the data window low lane and 3 is the data window high lane. `bus_word` high means a 16-bit access and low means a byte access.

Top module: `vreg_port`

## Requirements
- R1: A synchronous reset clears the voice select, function select, voice count, control bits and every voice register to zero.
- R2: Writing location 0 or 1 stores `bus_wdata[7:0]`, which reads back zero-extended. Only bits 4:0 of the voice select and bits 3:0 of the function select take part in addressing, so voice 0x25 reaches the same registers as voice 5.
- R3: The selected register is word index voice*16 + function. Every one of the 32x14 voice registers is stored independently of the others.
- R4: With function 0x00..0x0D, a word write to the data window replaces all 16 bits of the selected register.
- R5: A byte write to location 2 replaces bits 7:0 with `bus_wdata[7:0]` and keeps bits 15:8.
- R6: A byte write to location 3 places `bus_wdata[7:0]` in bits 15:8 and keeps bits 7:0.
- R7: With function 0x80..0x8D, a word read returns the whole register. A byte read returns bits 7:0 from location 2, or bits 15:8 from location 3, on `bus_rdata[7:0]`, with the upper byte zero.
- R8: While the run flag (control bit 0) is 0, writes to voice registers leave them unchanged.
- R9: Function 0x0E writes `bus_wdata[7:0]` into the voice count. Function 0x8E reads it back zero-extended.
- R10: Function 0x4C writes `bus_wdata[7:0]` to the control register, where bit 0 is run, bit 1 is interrupt enable and bit 2 is DAC enable. When bit 0 of the data is 0, bits 1 and 2 are forced to 0 and the voice count becomes 0xCD.
- R11: A data window read with any function code other than 0x80..0x8E returns 0xFFFF.
- R12: A data window write with a function code outside 0x00..0x0E and other than 0x4C changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Location: 0 voice select, 1 function select, 2 data low lane, 3 data high lane |
| bus_word | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the current selects and location |
| run_en | output | 1 | Control bit 0, gates voice register writes |
| irq_en | output | 1 | Control bit 1, interrupt enable |
| dac_en | output | 1 | Control bit 2, DAC enable |

## Verification
Every write lands at the rising edge that ends its strobe cycle, so a select, control or register update is visible one edge after the strobe. Reads are combinational from the registers and the present location and function code, so their result is due in the same cycle. The bench drives each access at a falling edge and samples read data one time unit later, never close to a rising edge. The control outputs are sampled after the edge that takes the control write.

// File: rtl/vreg_pkg.sv
package vreg_pkg;
   typedef enum logic [1:0] {
      LOC_VOICE = 2'd0,
      LOC_FUNC  = 2'd1,
      LOC_DLO   = 2'd2,
      LOC_DHI   = 2'd3
   } loc_e;
endpackage

// File: rtl/vreg_addr_gen.sv
module vreg_addr_gen #(
   parameter int LANE_W     = 8,
   parameter int VOICE_BITS = 5,
   parameter int FUNC_BITS  = 4
) (
   input  logic [LANE_W-1:0]               voice_sel,
   input  logic [LANE_W-1:0]               func_sel,
   output logic [VOICE_BITS+FUNC_BITS-1:0] word_addr
);
   initial begin : elab_chk
      if (VOICE_BITS > LANE_W || FUNC_BITS > LANE_W)
         $fatal(1, "vreg_addr_gen: select field wider than lane");
   end

   // upper select bits fold away (aliasing)
   logic [LANE_W-VOICE_BITS-1:0] voice_unused;
   logic [LANE_W-FUNC_BITS-1:0]  func_unused;
   assign voice_unused = voice_sel[LANE_W-1:VOICE_BITS];
   assign func_unused  = func_sel[LANE_W-1:FUNC_BITS];

   assign word_addr = {voice_sel[VOICE_BITS-1:0], func_sel[FUNC_BITS-1:0]};
endmodule

// File: rtl/vreg_lanes.sv
module vreg_lanes #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] cur_word,
   input  logic [DATA_W-1:0] wdata,
   input  logic              is_word,
   input  logic              is_hi,
   output logic [DATA_W-1:0] merged,
   output logic [DATA_W-1:0] rd_lane
);
   localparam int LANE_W = DATA_W / 2;

   initial begin : elab_chk
      if (DATA_W % 2 != 0) $fatal(1, "vreg_lanes: DATA_W must be even");
   end

   always_comb begin
      if (is_word)    merged = wdata;
      else if (is_hi) merged = {wdata[LANE_W-1:0], cur_word[LANE_W-1:0]};
      else            merged = {cur_word[DATA_W-1:LANE_W], wdata[LANE_W-1:0]};
   end

   always_comb begin
      if (is_word)    rd_lane = cur_word;
      else if (is_hi) rd_lane = {{LANE_W{1'b0}}, cur_word[DATA_W-1:LANE_W]};
      else            rd_lane = {{LANE_W{1'b0}}, cur_word[LANE_W-1:0]};
   end
endmodule

// File: rtl/vreg_file.sv
module vreg_file #(
   parameter int ADDR_W         = 9,
   parameter int DATA_W         = 16,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   initial begin : elab_chk
      if (DEPTH > 4096) $fatal(1, "vreg_file: depth too large");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[addr] <= wdata;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (we) mem[addr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[addr];
endmodule

// File: rtl/vreg_port.sv
module vreg_port #(
   parameter int DATA_W     = 16,
   parameter int VOICE_BITS = 5,
   parameter int FUNC_BITS  = 4,
   parameter int NUM_FUNCS  = 14,
   parameter int RD_OFFSET  = 8'h80,
   parameter int CTRL_CODE  = 8'h4C,
   parameter int COUNT_INIT = 8'hCD
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        bus_addr,
   input  logic              bus_word,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              run_en,
   output logic              irq_en,
   output logic              dac_en
);
   import vreg_pkg::*;

   localparam int LANE_W = DATA_W / 2;
   localparam int ADDR_W = VOICE_BITS + FUNC_BITS;
   localparam logic [LANE_W-1:0] WR_LAST  = LANE_W'(NUM_FUNCS);
   localparam logic [LANE_W-1:0] RD_BASE  = LANE_W'(RD_OFFSET);
   localparam logic [LANE_W-1:0] RD_LAST  = LANE_W'(RD_OFFSET + NUM_FUNCS);
   localparam logic [LANE_W-1:0] CNT_WR   = LANE_W'(NUM_FUNCS);
   localparam logic [LANE_W-1:0] CNT_RD   = LANE_W'(RD_OFFSET + NUM_FUNCS);
   localparam logic [LANE_W-1:0] CTRL_FN  = LANE_W'(CTRL_CODE);
   localparam logic [LANE_W-1:0] CNT_LOAD = LANE_W'(COUNT_INIT);
   localparam logic [LANE_W-1:0] EN_MASK  = LANE_W'(6);

   initial begin : elab_chk
      if (NUM_FUNCS >= (1 << FUNC_BITS)) $fatal(1, "vreg_port: NUM_FUNCS too big");
      if (LANE_W < 3) $fatal(1, "vreg_port: lane too narrow for control bits");
   end

   loc_e loc;
   assign loc = loc_e'(bus_addr);

   logic [LANE_W-1:0] voice_q, func_q, count_q, ctrl_q;
   logic              is_data, is_hi, wr_voice_fn, rd_voice_fn, vf_we;
   logic [ADDR_W-1:0] word_addr;
   logic [DATA_W-1:0] cur_word, merged, rd_lane;

   assign is_data     = (loc == LOC_DLO) || (loc == LOC_DHI);
   assign is_hi       = (loc == LOC_DHI);
   assign wr_voice_fn = func_q < WR_LAST;
   assign rd_voice_fn = (func_q >= RD_BASE) && (func_q < RD_LAST);
   assign vf_we       = bus_wr && is_data && wr_voice_fn && ctrl_q[0];

   vreg_addr_gen #(.LANE_W(LANE_W), .VOICE_BITS(VOICE_BITS), .FUNC_BITS(FUNC_BITS)) u_addr (
      .voice_sel(voice_q), .func_sel(func_q), .word_addr(word_addr));

   vreg_lanes #(.DATA_W(DATA_W)) u_lanes (
      .cur_word(cur_word), .wdata(bus_wdata), .is_word(bus_word), .is_hi(is_hi),
      .merged(merged), .rd_lane(rd_lane));

   vreg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLEAR_ON_RESET(1'b1)) u_file (
      .clk(clk), .rst(rst), .we(vf_we), .addr(word_addr), .wdata(merged), .rdata(cur_word));

   // select, count and control registers
   always_ff @(posedge clk) begin
      if (rst) begin
         voice_q <= '0;
         func_q  <= '0;
         count_q <= '0;
         ctrl_q  <= '0;
      end else if (bus_wr) begin
         unique case (loc)
            LOC_VOICE: voice_q <= bus_wdata[LANE_W-1:0];
            LOC_FUNC:  func_q  <= bus_wdata[LANE_W-1:0];
            default: begin
               if (func_q == CNT_WR) begin
                  count_q <= bus_wdata[LANE_W-1:0];
               end else if (func_q == CTRL_FN) begin
                  if (bus_wdata[0]) begin
                     ctrl_q <= bus_wdata[LANE_W-1:0];
                  end else begin
                     ctrl_q  <= bus_wdata[LANE_W-1:0] & ~EN_MASK;
                     count_q <= CNT_LOAD;
                  end
               end
            end
         endcase
      end
   end

   always_comb begin
      bus_rdata = '1;
      unique case (loc)
         LOC_VOICE: bus_rdata = {{LANE_W{1'b0}}, voice_q};
         LOC_FUNC:  bus_rdata = {{LANE_W{1'b0}}, func_q};
         default: begin
            if (rd_voice_fn)          bus_rdata = rd_lane;
            else if (func_q == CNT_RD) bus_rdata = {{LANE_W{1'b0}}, count_q};
         end
      endcase
   end

   assign run_en = ctrl_q[0];
   assign irq_en = ctrl_q[1];
   assign dac_en = ctrl_q[2];
endmodule

// File: rtl/vreg_port_chk.sv
module vreg_port_chk #(
   parameter int DATA_W    = 16,
   parameter int NUM_FUNCS = 14,
   parameter int RD_OFFSET = 8'h80,
   parameter int CTRL_CODE = 8'h4C
) (
   input logic              clk,
   input logic              rst,
   input logic [1:0]        bus_addr,
   input logic              bus_word,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              run_en,
   input logic              irq_en,
   input logic              dac_en,
   input logic [DATA_W/2-1:0] voice_q,
   input logic [DATA_W/2-1:0] func_q,
   input logic              vf_we
);
   localparam int LANE_W = DATA_W / 2;
   localparam logic [LANE_W-1:0] RD_BASE = LANE_W'(RD_OFFSET);
   localparam logic [LANE_W-1:0] RD_LAST = LANE_W'(RD_OFFSET + NUM_FUNCS);
   localparam logic [LANE_W-1:0] CTRL_FN = LANE_W'(CTRL_CODE);

   logic on_data, rd_vreg, rd_known;
   assign on_data  = bus_addr[1];
   assign rd_vreg  = (func_q >= RD_BASE) && (func_q < RD_LAST);
   assign rd_known = (func_q >= RD_BASE) && (func_q <= RD_LAST);

   assert_reset_clear_R1: assert property (@(posedge clk)
      $past(rst) |-> (!run_en && !irq_en && !dac_en && voice_q == '0 && func_q == '0));

   assert_voice_sel_R2: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == 2'd0) |=> (voice_q == $past(bus_wdata[LANE_W-1:0])));

   assert_byte_read_R7: assert property (@(posedge clk) disable iff (rst)
      (!bus_wr && on_data && !bus_word && rd_vreg) |-> (bus_rdata[DATA_W-1:LANE_W] == '0));

   assert_write_gate_R8: assert property (@(posedge clk) disable iff (rst)
      !run_en |-> !vf_we);

   assert_ctrl_clear_R10: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && on_data && func_q == CTRL_FN && !bus_wdata[0]) |=> (!run_en && !irq_en && !dac_en));

   assert_undecoded_R11: assert property (@(posedge clk) disable iff (rst)
      (!bus_wr && on_data && !rd_known) |-> (bus_rdata == '1));
endmodule

bind vreg_port vreg_port_chk #(
   .DATA_W(DATA_W), .NUM_FUNCS(NUM_FUNCS), .RD_OFFSET(RD_OFFSET), .CTRL_CODE(CTRL_CODE)
) u_chk (
   .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_word(bus_word), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .run_en(run_en), .irq_en(irq_en),
   .dac_en(dac_en), .voice_q(voice_q), .func_q(func_q), .vf_we(vf_we)
);

// File: tb/vreg_port_tb.sv
module vreg_port_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  bus_addr = 2'd0;
   logic        bus_word = 1'b1;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;
   logic        run_en, irq_en, dac_en;

   int checks = 0;
   int fails = 0;
   logic [15:0] ref_mem [512];

   always #(CLK_PERIOD / 2) clk = ~clk;

   vreg_port u_dut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_word(bus_word), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .run_en(run_en), .irq_en(irq_en),
      .dac_en(dac_en));

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic w, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_word = w; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic w, output logic [15:0] q);
      @(negedge clk);
      bus_addr = a; bus_word = w; bus_wr = 1'b0;
      #1 q = bus_rdata;
   endtask

   task automatic sel(input logic [7:0] v, input logic [7:0] f);
      wr(2'd0, 1'b1, {8'h00, v});
      wr(2'd1, 1'b1, {8'h00, f});
   endtask

   function automatic int idx(input int v, input int f);
      return (v % 32) * 16 + (f % 16);
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [15:0] q, p;
      for (int i = 0; i < 512; i++) ref_mem[i] = 16'h0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;

      // R1 reset state
      check("R1 run", {15'h0, run_en}, 16'h0);
      check("R1 irq", {15'h0, irq_en}, 16'h0);
      check("R1 dac", {15'h0, dac_en}, 16'h0);
      rd(2'd0, 1'b1, q); check("R1 voice sel", q, 16'h0);
      rd(2'd1, 1'b1, q); check("R1 func sel", q, 16'h0);
      sel(8'd9, 8'h86);
      rd(2'd2, 1'b1, q); check("R1 voice reg", q, 16'h0);
      wr(2'd1, 1'b1, 16'h008E);
      rd(2'd2, 1'b1, q); check("R1 count", q, 16'h0);

      // R10 enable all
      wr(2'd1, 1'b1, 16'h004C);
      wr(2'd2, 1'b1, 16'h0007);
      check("R10 run set", {15'h0, run_en}, 16'h1);
      check("R10 irq set", {15'h0, irq_en}, 16'h1);
      check("R10 dac set", {15'h0, dac_en}, 16'h1);

      // R3 R4 full sweep of word writes
      for (int v = 0; v < 32; v++) begin
         for (int f = 0; f < 14; f++) begin
            p = 16'((v * 16 + f) * 16'h0123) ^ 16'h5A5A;
            sel(8'(v), 8'(f));
            wr(f[0] ? 2'd3 : 2'd2, 1'b1, p);
            ref_mem[idx(v, f)] = p;
         end
      end
      for (int v = 0; v < 32; v++) begin
         for (int f = 0; f < 14; f++) begin
            sel(8'(v), 8'(8'h80 + f));
            rd(2'd2, 1'b1, q);
            check("R3 R4 word sweep", q, ref_mem[idx(v, f)]);
         end
      end

      // R5 R6 R7 byte lanes
      for (int v = 0; v < 32; v++) begin
         int f;
         f = v % 14;
         sel(8'(v), 8'(f));
         wr(2'd2, 1'b0, 16'hEE00 | 16'(v));
         ref_mem[idx(v, f)] = {ref_mem[idx(v, f)][15:8], 8'(v)};
         wr(2'd3, 1'b0, 16'hFF00 | 16'(v + 8'h40));
         ref_mem[idx(v, f)] = {8'(v + 8'h40), ref_mem[idx(v, f)][7:0]};
         wr(2'd1, 1'b1, 16'(8'h80 + f));
         rd(2'd3, 1'b1, q); check("R5 R6 merged word", q, ref_mem[idx(v, f)]);
         rd(2'd2, 1'b0, q); check("R7 low byte", q, {8'h00, ref_mem[idx(v, f)][7:0]});
         rd(2'd3, 1'b0, q); check("R7 high byte", q, {8'h00, ref_mem[idx(v, f)][15:8]});
      end

      // R2 aliasing of upper select bits
      sel(8'h25, 8'h03);
      wr(2'd2, 1'b1, 16'hBEEF);
      ref_mem[idx(5, 3)] = 16'hBEEF;
      rd(2'd0, 1'b1, q); check("R2 voice sel readback", q, 16'h0025);
      sel(8'h05, 8'h83);
      rd(2'd2, 1'b1, q); check("R2 alias voice", q, 16'hBEEF);
      rd(2'd1, 1'b1, q); check("R2 func sel readback", q, 16'h0083);

      // R9 voice count
      wr(2'd1, 1'b1, 16'h000E);
      wr(2'd2, 1'b1, 16'h1234);
      wr(2'd1, 1'b1, 16'h008E);
      rd(2'd2, 1'b1, q); check("R9 count", q, 16'h0034);

      // R11 undecoded reads
      wr(2'd1, 1'b1, 16'h000E); rd(2'd2, 1'b1, q); check("R11 func 0E", q, 16'hFFFF);
      wr(2'd1, 1'b1, 16'h008F); rd(2'd2, 1'b1, q); check("R11 func 8F", q, 16'hFFFF);
      wr(2'd1, 1'b1, 16'h004C); rd(2'd3, 1'b0, q); check("R11 func 4C", q, 16'hFFFF);
      wr(2'd1, 1'b1, 16'h0093); rd(2'd2, 1'b1, q); check("R11 func 93", q, 16'hFFFF);
      wr(2'd1, 1'b1, 16'h007F); rd(2'd2, 1'b1, q); check("R11 func 7F", q, 16'hFFFF);

      // R12 writes with read-side codes change nothing
      sel(8'd2, 8'h85);
      wr(2'd2, 1'b1, 16'h1111);
      wr(2'd1, 1'b1, 16'h0013);
      wr(2'd2, 1'b1, 16'h2222);
      wr(2'd1, 1'b1, 16'h0085);
      rd(2'd2, 1'b1, q); check("R12 func 85 write ignored", q, ref_mem[idx(2, 5)]);
      wr(2'd1, 1'b1, 16'h0083);
      rd(2'd2, 1'b1, q); check("R12 func 13 write ignored", q, ref_mem[idx(2, 3)]);
      wr(2'd1, 1'b1, 16'h008E);
      rd(2'd2, 1'b1, q); check("R12 count kept", q, 16'h0034);

      // R10 clearing run
      wr(2'd1, 1'b1, 16'h004C);
      wr(2'd2, 1'b1, 16'h0006);
      check("R10 run clear", {15'h0, run_en}, 16'h0);
      check("R10 irq clear", {15'h0, irq_en}, 16'h0);
      check("R10 dac clear", {15'h0, dac_en}, 16'h0);
      wr(2'd1, 1'b1, 16'h008E);
      rd(2'd2, 1'b1, q); check("R10 count load", q, 16'h00CD);

      // R8 gated writes
      sel(8'd7, 8'h01);
      wr(2'd2, 1'b1, 16'hAAAA);
      wr(2'd3, 1'b0, 16'h0055);
      wr(2'd1, 1'b1, 16'h0081);
      rd(2'd2, 1'b1, q); check("R8 gated write", q, ref_mem[idx(7, 1)]);

      // R8 R10 re-enable
      wr(2'd1, 1'b1, 16'h004C);
      wr(2'd2, 1'b1, 16'h0003);
      check("R10 run again", {15'h0, run_en}, 16'h1);
      check("R10 irq again", {15'h0, irq_en}, 16'h1);
      check("R10 dac stays", {15'h0, dac_en}, 16'h0);
      wr(2'd1, 1'b1, 16'h0001);
      wr(2'd2, 1'b1, 16'hAAAA);
      wr(2'd1, 1'b1, 16'h0081);
      rd(2'd2, 1'b1, q); check("R8 write after enable", q, 16'hAAAA);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule